// File: doc/BRIEF.md
# Grouped Interrupt Vector Controller

The controller collects single-cycle interrupt vector events and records each one in a pending status bit. The vectors are organised in groups of 32. Each group has its own 32-bit pending word, its own 32-bit enable word and its own interrupt line toward a parent interrupt controller. A group's line is raised while at least one vector in that group is both pending and enabled.

Software reaches the block through a plain 32-bit register port: a byte address, write data, a write strobe, a read strobe and registered read data. Pending words sit in a low bank and are cleared by writing ones. Enable words sit in a second bank that starts at byte offset 0x20. Software reads them, changes them and writes them back to mask or unmask single vectors.

Pending bits hold their value whatever the input is doing. They keep latching while a vector is masked, so unmasking a vector that is already pending raises its group line at once.

Top module: `grp_irq_vec_ctrl`

## Requirements
- R1: An event carries an 8-bit vector number n. Bits [4:0] select bit n%32 and bits [7:5] select group n/32 (word n/32). An event whose group is not below NUM_GROUPS sets nothing.
- R2: A read at byte offset 4*i, for i below NUM_GROUPS, returns the pending word of group i.
- R3: A write at byte offset 0x20+4*i replaces the enable word of group i, and a read at that offset returns the last value written.
- R4: `ev_valid` is sampled high at a clock edge. From the next cycle on, the addressed pending bit is set, and no other pending bit changes because of that event.
- R5: A set pending bit stays set on every later cycle until software writes a 1 to it. This holds after `ev_valid` falls.
- R6: Writing a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing 0xFFFFFFFF clears the whole group.
- R7: `irq_out[i]` is high exactly while (pending_i AND enable_i) is non-zero. It follows the registers in the cycle they change.
- R8: A masked vector still latches its pending bit. Setting its enable bit afterwards raises the group line in the cycle after the write.
- R9: An event and a write-one-to-clear of the same bit can arrive in the same cycle. In that case the bit ends up set.
- R10: After reset every pending bit and every enable bit is 0, and every `irq_out` line is low.
- R11: Unused offsets read as zero and ignore writes. Unused offsets are any address with bits [1:0] non-zero, any address past the last enable word, and the gap between the two banks.
- R12: `reg_rdata` takes the addressed value one cycle after the edge that samples `reg_rd` high. It holds its value while `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | One vector event in this cycle |
| ev_vector | input | 8 | Vector number of the event |
| reg_addr | input | ADDR_W | Byte address of register access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_GROUPS | One interrupt line per group |

## Verification
A corrupted pending bit shows in two places. It shows on its group's line in the same cycle, if the vector is enabled. It also shows in the data of the next read of that pending word. A wrong enable bit is invisible until a matching vector becomes pending, so the bench always pairs a pending state with both enable states. A wrong decode in the register port either clears or masks a vector in the wrong group, or leaks data onto unused offsets. The bench therefore reads neighbouring words and unused addresses right after each write.

// File: rtl/gvc_pkg.sv
package gvc_pkg;
    localparam int WORD_W   = 32;
    localparam int BIT_W    = 5;
    localparam int VEC_W    = 8;
    localparam int GRP_W    = VEC_W - BIT_W;
    localparam int MAX_GRPS = 1 << GRP_W;

    typedef enum logic [1:0] {
        BANK_NONE = 2'd0,
        BANK_PEND = 2'd1,
        BANK_ENAB = 2'd2
    } bank_e;

    typedef struct packed {
        logic [WORD_W-1:0] pend;
        logic [WORD_W-1:0] enab;
    } grp_state_t;
endpackage

// File: rtl/gvc_addr_decode.sv
module gvc_addr_decode
    import gvc_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int ADDR_W     = 8,
    parameter int ENAB_BASE  = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output bank_e             bank,
    output logic [GRP_W-1:0]  grp
);
    localparam int PEND_END = 4 * NUM_GROUPS;
    localparam int ENAB_END = ENAB_BASE + 4 * NUM_GROUPS;

    always_comb begin
        int a;
        a    = int'(addr);
        bank = BANK_NONE;
        grp  = '0;
        if (addr[1:0] == 2'b00) begin
            if (a < PEND_END) begin
                bank = BANK_PEND;
                grp  = GRP_W'(a >> 2);
            end else if (a >= ENAB_BASE && a < ENAB_END) begin
                bank = BANK_ENAB;
                grp  = GRP_W'((a - ENAB_BASE) >> 2);
            end
        end
    end
endmodule

// File: rtl/gvc_group.sv
module gvc_group
    import gvc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_hit,
    input  logic [BIT_W-1:0]  ev_bit,
    input  logic              wr_pend,
    input  logic              wr_enab,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] pend,
    output logic [WORD_W-1:0] enab,
    output logic              irq
);
    grp_state_t st_d, st_q;

    always_comb begin
        logic [WORD_W-1:0] set_mask;
        logic [WORD_W-1:0] clr_mask;
        set_mask = ev_hit  ? (WORD_W'(1) << ev_bit) : '0;
        clr_mask = wr_pend ? wdata : '0;
        st_d     = st_q;
        // a new event overrides a clear of the same bit
        st_d.pend = (st_q.pend & ~clr_mask) | set_mask;
        if (wr_enab) begin
            st_d.enab = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign enab = st_q.enab;
    assign irq  = |(st_q.pend & st_q.enab);
endmodule

// File: rtl/gvc_rd_port.sv
module gvc_rd_port
    import gvc_pkg::*;
#(
    parameter int NUM_GROUPS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd,
    input  bank_e                        bank,
    input  logic [GRP_W-1:0]             grp,
    input  logic [NUM_GROUPS*WORD_W-1:0] pend_all,
    input  logic [NUM_GROUPS*WORD_W-1:0] enab_all,
    output logic [WORD_W-1:0]            rdata
);
    logic [WORD_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd) begin
            rdata_d = '0;
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (int'(grp) == g) begin
                    if (bank == BANK_PEND) rdata_d = pend_all[g*WORD_W +: WORD_W];
                    if (bank == BANK_ENAB) rdata_d = enab_all[g*WORD_W +: WORD_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/grp_irq_vec_ctrl.sv
module grp_irq_vec_ctrl
    import gvc_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int ADDR_W     = 8,
    parameter int ENAB_BASE  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ev_valid,
    input  logic [7:0]            ev_vector,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    output logic [31:0]           reg_rdata,
    output logic [NUM_GROUPS-1:0] irq_out
);
    localparam int ALL_W = NUM_GROUPS * WORD_W;

    bank_e             dec_bank;
    logic [GRP_W-1:0]  dec_grp;
    logic [ALL_W-1:0]  pend_all;
    logic [ALL_W-1:0]  enab_all;
    logic [GRP_W-1:0]  ev_grp;
    logic [BIT_W-1:0]  ev_bit;

    assign ev_grp = ev_vector[VEC_W-1:BIT_W];
    assign ev_bit = ev_vector[BIT_W-1:0];

    gvc_addr_decode #(
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W),
        .ENAB_BASE  (ENAB_BASE)
    ) u_dec (
        .addr (reg_addr),
        .bank (dec_bank),
        .grp  (dec_grp)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit, wp, we;
        assign hit = ev_valid && (int'(ev_grp) == g);
        assign wp  = reg_wr && (dec_bank == BANK_PEND) && (int'(dec_grp) == g);
        assign we  = reg_wr && (dec_bank == BANK_ENAB) && (int'(dec_grp) == g);

        gvc_group u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_hit  (hit),
            .ev_bit  (ev_bit),
            .wr_pend (wp),
            .wr_enab (we),
            .wdata   (reg_wdata),
            .pend    (pend_all[g*WORD_W +: WORD_W]),
            .enab    (enab_all[g*WORD_W +: WORD_W]),
            .irq     (irq_out[g])
        );
    end

    gvc_rd_port #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (reg_rd),
        .bank     (dec_bank),
        .grp      (dec_grp),
        .pend_all (pend_all),
        .enab_all (enab_all),
        .rdata    (reg_rdata)
    );
endmodule

// File: rtl/gvc_checker.sv
module gvc_checker #(
    parameter int NUM_GROUPS = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ev_valid,
    input logic                         reg_wr,
    input logic                         reg_rd,
    input logic [31:0]                  reg_rdata,
    input logic [NUM_GROUPS-1:0]        irq_out,
    input logic [NUM_GROUPS*32-1:0]     pend_all,
    input logic [NUM_GROUPS*32-1:0]     enab_all
);
    // R10: state is clear on the first cycle out of reset
    a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend_all == '0 && enab_all == '0));

    // R4: without an event no pending bit rises
    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> ((pend_all & ~$past(pend_all)) == '0));

    // R5: without a write no pending bit falls
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((pend_all & $past(pend_all)) == $past(pend_all)));

    // R3: enables only move on a write
    a_r3_enab_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(enab_all));

    // R7: with everything masked all lines are low
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enab_all == '0) |-> (irq_out == '0));

    // R7: with nothing pending all lines are low
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_all == '0) |-> (irq_out == '0));

    // R12: read data holds when no read is made
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind grp_irq_vec_ctrl gvc_checker #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .pend_all  (pend_all),
    .enab_all  (enab_all)
);

// File: tb/test_grp_irq_vec_ctrl.sv
module test_grp_irq_vec_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [7:0]  ev_vector = '0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic [NG-1:0] irq_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    grp_irq_vec_ctrl i_grp_irq_vec_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_vector(ev_vector),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic ev(input logic [7:0] v);
        @(negedge clk);
        ev_vector = v; ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R10 irq", 32'(irq_out), 32'h0);
        for (int g = 0; g < NG; g++) begin
            rd(8'(4*g), d);        check("R10 pend", d, 32'h0);
            rd(8'(32 + 4*g), d);   check("R10 enab", d, 32'h0);
        end
    endtask

    task automatic t_latch_and_mask;
        logic [31:0] d;
        ev(8'h47);
        rd(8'h08, d); check("R1 R4 pend word 2", d, 32'h0000_0080);
        rd(8'h0C, d); check("R4 word 3 untouched", d, 32'h0);
        rd(8'h00, d); check("R4 word 0 untouched", d, 32'h0);
        check("R8 masked line low", 32'(irq_out), 32'h0);
        wr(8'h28, 32'h0000_0080);
        check("R8 R7 line after unmask", 32'(irq_out), 32'h0000_0004);
        rd(8'h28, d); check("R3 enable readback", d, 32'h0000_0080);
        repeat (5) @(negedge clk);
        rd(8'h08, d); check("R5 sticky", d, 32'h0000_0080);
        wr(8'h28, 32'h0000_0001);
        check("R7 line drops when masked", 32'(irq_out), 32'h0);
        wr(8'h28, 32'h0000_0081);
        check("R7 line back", 32'(irq_out), 32'h0000_0004);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        wr(8'h08, 32'h0000_0000);
        rd(8'h08, d); check("R6 zero write keeps", d, 32'h0000_0080);
        wr(8'h08, 32'h0000_0080);
        rd(8'h08, d); check("R6 one clears", d, 32'h0);
        check("R7 line low after clear", 32'(irq_out), 32'h0);
        ev(8'hE0); ev(8'hFF);
        rd(8'h1C, d); check("R1 group 7 bits", d, 32'h8000_0001);
        wr(8'h1C, 32'h8000_0000);
        rd(8'h1C, d); check("R6 partial clear", d, 32'h0000_0001);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, d); check("R6 all-ones clear", d, 32'h0);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        ev(8'h43);
        @(negedge clk);
        ev_vector = 8'h47; ev_valid = 1'b1;
        reg_addr = 8'h08; reg_wdata = 32'h0000_0088; reg_wr = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0; reg_wr = 1'b0;
        rd(8'h08, d); check("R9 set wins, other cleared", d, 32'h0000_0080);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d); check("R6 cleanup", d, 32'h0);
    endtask

    task automatic t_all_groups;
        logic [31:0] d;
        for (int g = 0; g < NG; g++) ev(8'(32*g + 3*g + 1));
        for (int g = 0; g < NG; g++) begin
            rd(8'(4*g), d);
            check("R1 R2 per-group word", d, 32'h1 << (3*g + 1));
        end
        for (int g = 0; g < NG; g++) wr(8'(32 + 4*g), 32'hFFFF_FFFF);
        check("R7 all lines", 32'(irq_out), 32'h0000_00FF);
        wr(8'h14, 32'hFFFF_FFFF);
        check("R7 group 5 only drops", 32'(irq_out), 32'h0000_00DF);
    endtask

    task automatic t_unused;
        logic [31:0] d;
        wr(8'h40, 32'h0);
        wr(8'h22, 32'h0);
        wr(8'h09, 32'hFFFF_FFFF);
        check("R11 lines unchanged", 32'(irq_out), 32'h0000_00DF);
        rd(8'h20, d); check("R11 enable 0 unchanged", d, 32'hFFFF_FFFF);
        rd(8'h08, d); check("R11 pend 2 unchanged", d, 32'h0000_0080);
        rd(8'h40, d); check("R11 read 0x40", d, 32'h0);
        rd(8'h22, d); check("R11 read misaligned", d, 32'h0);
        rd(8'hFC, d); check("R11 read top", d, 32'h0);
    endtask

    task automatic t_read_timing;
        logic [31:0] d;
        rd(8'h08, d); check("R12 read data", d, 32'h0000_0080);
        ev(8'h45);
        @(negedge clk);
        check("R12 hold without read", reg_rdata, 32'h0000_0080);
        @(negedge clk);
        reg_addr = 8'h08; reg_rd = 1'b1;
        check("R12 not yet updated", reg_rdata, 32'h0000_0080);
        @(negedge clk);
        reg_rd = 1'b0;
        check("R12 updated next cycle", reg_rdata, 32'h0000_00A0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_and_mask();
        t_w1c();
        t_collision();
        t_all_groups();
        t_unused();
        t_read_timing();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule